// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between a pipelined converter core and the output pins. On every sample the core marks valid, it takes the raw 14-bit offset-binary code and its overflow flag. It applies the selected coding and scrambling, or replaces the sample with a fixed diagnostic pattern. It then registers the result for the pins. Samples go out either as one full-width word or as two half-width lanes for double-data-rate packing.

All configuration inputs are static-level fields sampled together with each valid sample. A one-bit sample phase starts at 0 after reset and flips on every valid sample. Phase-dependent features use the phase value from before the flip: the first sample after reset has phase 0, the second phase 1, and so on.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is asserted and after it is released with no sample, out_vld, out_ovf, out_data, ddr_even and ddr_odd are all zero.
- R2: A sample presented with smp_vld high and cfg_oe high appears on the outputs one clock later, with out_vld high for exactly one clock. The outputs hold their value while no valid sample arrives. In live mode the overflow flag passes through unchanged.
- R3: With cfg_twos high, bit 13 of the code is inverted (two's complement); with it low, the offset-binary code is kept.
- R4: With cfg_rand high, bits 13..1 are each XORed with bit 0, and bit 0 is unchanged.
- R5: With cfg_abp high and cfg_twos low, the odd-numbered data bits (mask 0x2AAA) are inverted on phase-1 samples only.
- R6: Alternate bit polarity has no effect while cfg_twos is high.
- R7: The live path applies coding first, then the randomizer, then bit polarity.
- R8: cfg_pat codes: 0 = live data; 1 = overflow and all data bits one; 2 = all zero; 3 = checkerboard; 4 = alternating; 5 to 7 act as live data.
- R9: The checkerboard gives overflow=1 and data 0x15A5 on phase-0 samples, and overflow=0 and data 0x2A5A on phase-1 samples.
- R10: The alternating pattern gives all ones (overflow included) on phase-0 samples and all zeros on phase-1 samples.
- R11: With cfg_oe low, every output is zero one clock later and out_vld stays low. A valid sample presented while disabled still advances the sample phase.
- R12: With cfg_ddr high, out_data is zero. ddr_even bit k carries data bit 2k and ddr_odd bit k carries data bit 2k+1. With cfg_ddr low, both lanes are zero. Overflow appears on out_ovf in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Raw sample valid strobe |
| smp_code | input | 14 | Raw offset-binary code |
| smp_ovf | input | 1 | Raw overflow flag |
| cfg_pat | input | 3 | Pattern select |
| cfg_twos | input | 1 | Two's complement coding |
| cfg_abp | input | 1 | Alternate bit polarity enable |
| cfg_rand | input | 1 | Randomizer enable |
| cfg_ddr | input | 1 | Double-data-rate packing |
| cfg_oe | input | 1 | Output enable |
| out_data | output | 14 | Full-rate formatted data |
| out_ovf | output | 1 | Formatted overflow |
| ddr_even | output | 7 | DDR lanes, first-half (even) bits |
| ddr_odd | output | 7 | DDR lanes, second-half (odd) bits |
| out_vld | output | 1 | Output data valid |

## Verification
The only hidden state is the sample phase. If the phase is wrong, the next phase-dependent sample shows it: a checkerboard or alternating pattern comes out with the wrong polarity, or the bit-polarity mask appears on the wrong sample. This shows up one clock after that sample is presented. The bench keeps its own count of valid samples, including those presented while the outputs are disabled, so a phase that fails to advance shows up at once. Every other error in the data path is visible on the very next output word.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int DW = 14,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_code,
  input  logic          smp_ovf,
  input  logic [2:0]    cfg_pat,
  input  logic          cfg_twos,
  input  logic          cfg_abp,
  input  logic          cfg_rand,
  input  logic          cfg_ddr,
  input  logic          cfg_oe,
  output logic [DW-1:0] out_data,
  output logic          out_ovf,
  output logic [HW-1:0] ddr_even,
  output logic [HW-1:0] ddr_odd,
  output logic          out_vld
);

  function automatic logic [DW-1:0] odd_mask();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  function automatic logic [DW-1:0] chk_word();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((i % 2) == 0) ^ (i >= 4 && i < 8);
    return m;
  endfunction

  localparam logic [DW-1:0] ODD = odd_mask();
  localparam logic [DW-1:0] CHK = chk_word();
  localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};

  logic          phase_q, vld_q, ddr_q;
  logic [DW:0]   word_q, nxt;
  logic [DW-1:0] conv, rnd, pol;

  assign conv = cfg_twos ? smp_code ^ MSB : smp_code;
  assign rnd  = cfg_rand ? conv ^ {{(DW-1){conv[0]}}, 1'b0} : conv;
  assign pol  = (cfg_abp && !cfg_twos && phase_q) ? rnd ^ ODD : rnd;

  always_comb begin
    case (cfg_pat)
      3'd1:    nxt = '1;
      3'd2:    nxt = '0;
      3'd3:    nxt = phase_q ? {1'b0, ~CHK} : {1'b1, CHK};
      3'd4:    nxt = phase_q ? '0 : '1;
      default: nxt = {smp_ovf, pol};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      vld_q   <= 1'b0;
      ddr_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      if (smp_vld) phase_q <= ~phase_q;
      vld_q <= smp_vld & cfg_oe;
      if (!cfg_oe) begin
        word_q <= '0;
        ddr_q  <= 1'b0;
      end else if (smp_vld) begin
        word_q <= nxt;
        ddr_q  <= cfg_ddr;
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_ovf  = word_q[DW];
  assign out_data = ddr_q ? '0 : word_q[DW-1:0];

  for (genvar k = 0; k < HW; k++) begin : g_lane
    assign ddr_even[k] = ddr_q & word_q[2*k];
    assign ddr_odd[k]  = ddr_q & word_q[2*k+1];
  end

  // R11
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_oe) |-> (!out_vld && out_data == '0 && !out_ovf && ddr_even == '0 && ddr_odd == '0));

  // R2
  vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(smp_vld));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_oe) && !$past(smp_vld)) |-> ($stable(out_data) && $stable(out_ovf) && !out_vld));

  // R5
  phase_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> phase_q != $past(phase_q));

endmodule

// File: tb/adc_out_fmt_bench.sv
module adc_out_fmt_bench;
  logic        clk = 0, rst_n = 0;
  logic        smp_vld = 0, smp_ovf = 0;
  logic [13:0] smp_code = '0;
  logic [2:0]  cfg_pat = '0;
  logic        cfg_twos = 0, cfg_abp = 0, cfg_rand = 0, cfg_ddr = 0, cfg_oe = 1;
  logic [13:0] out_data;
  logic        out_ovf, out_vld;
  logic [6:0]  ddr_even, ddr_odd;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  adc_out_fmt u_adc_out_fmt (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code), .smp_ovf(smp_ovf),
    .cfg_pat(cfg_pat), .cfg_twos(cfg_twos), .cfg_abp(cfg_abp), .cfg_rand(cfg_rand),
    .cfg_ddr(cfg_ddr), .cfg_oe(cfg_oe), .out_data(out_data), .out_ovf(out_ovf),
    .ddr_even(ddr_even), .ddr_odd(ddr_odd), .out_vld(out_vld));

  // pat, twos, abp, rnd, ddr, ovf, code, exp_ovf, exp_data, exp_even, exp_odd
  localparam int NV = 17;
  localparam logic [50:0] TV [NV] = '{
    {3'd0, 4'b0000, 1'b0, 14'h1234, 1'b0, 14'h1234, 7'h00, 7'h00}, // R2 phase0
    {3'd0, 4'b1000, 1'b1, 14'h1234, 1'b1, 14'h3234, 7'h00, 7'h00}, // R3
    {3'd0, 4'b0010, 1'b0, 14'h0005, 1'b0, 14'h3FFB, 7'h00, 7'h00}, // R4
    {3'd0, 4'b0010, 1'b0, 14'h2AAA, 1'b0, 14'h2AAA, 7'h00, 7'h00}, // R4 bit0 clear
    {3'd0, 4'b0100, 1'b0, 14'h0F0F, 1'b0, 14'h0F0F, 7'h00, 7'h00}, // R5 phase0
    {3'd0, 4'b0100, 1'b0, 14'h0F0F, 1'b0, 14'h25A5, 7'h00, 7'h00}, // R5 phase1
    {3'd0, 4'b0000, 1'b0, 14'h0000, 1'b0, 14'h0000, 7'h00, 7'h00},
    {3'd0, 4'b1100, 1'b0, 14'h0F0F, 1'b0, 14'h2F0F, 7'h00, 7'h00}, // R6 phase1
    {3'd3, 4'b0000, 1'b0, 14'h1111, 1'b1, 14'h15A5, 7'h00, 7'h00}, // R9
    {3'd3, 4'b0000, 1'b0, 14'h1111, 1'b0, 14'h2A5A, 7'h00, 7'h00}, // R9
    {3'd4, 4'b0000, 1'b0, 14'h1111, 1'b1, 14'h3FFF, 7'h00, 7'h00}, // R10
    {3'd4, 4'b0000, 1'b1, 14'h1111, 1'b0, 14'h0000, 7'h00, 7'h00}, // R10
    {3'd1, 4'b0000, 1'b0, 14'h0000, 1'b1, 14'h3FFF, 7'h00, 7'h00}, // R8
    {3'd2, 4'b0000, 1'b1, 14'h3FFF, 1'b0, 14'h0000, 7'h00, 7'h00}, // R8
    {3'd0, 4'b1110, 1'b0, 14'h0001, 1'b0, 14'h1FFF, 7'h00, 7'h00}, // R7 phase0
    {3'd0, 4'b0110, 1'b0, 14'h0003, 1'b0, 14'h1557, 7'h00, 7'h00}, // R7 phase1
    {3'd0, 4'b0001, 1'b0, 14'h1234, 1'b0, 14'h0000, 7'h46, 7'h14}  // R12
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] p, input logic [3:0] f, input logic o, input logic [13:0] c);
    @(negedge clk);
    cfg_pat = p; {cfg_twos, cfg_abp, cfg_rand, cfg_ddr} = f;
    smp_ovf = o; smp_code = c; smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
  endtask

  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && out_data == 0 && out_ovf == 0 && ddr_even == 0 && ddr_odd == 0, "R1", out_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_vld == 0 && out_data == 0, "R1", out_vld, 0);

    for (int i = 0; i < NV; i++) begin
      send(TV[i][50:48], TV[i][47:44], TV[i][43], TV[i][42:29]);
      chk(out_vld == 1, "R2 valid", out_vld, 1);
      chk(out_data == TV[i][27:14] && out_ovf == TV[i][28], $sformatf("vector %0d", i),
          {out_ovf, out_data}, TV[i][28:14]);
      chk(ddr_even == TV[i][13:7] && ddr_odd == TV[i][6:0], "R12 lanes",
          {ddr_even, ddr_odd}, TV[i][13:0]);
    end

    // R2 hold: no valid sample, outputs unchanged and out_vld low
    @(negedge clk);
    chk(out_vld == 0 && ddr_even == 7'h46 && ddr_odd == 7'h14, "R2 hold", {ddr_even, ddr_odd}, 14'h2314);

    // R11: disabled, then phase still advanced
    rst_n = 0; @(negedge clk); rst_n = 1;
    cfg_oe = 0;
    send(3'd1, 4'b0000, 1'b1, 14'h3FFF);
    chk(out_vld == 0 && out_data == 0 && out_ovf == 0, "R11 disabled", {out_ovf, out_data}, 0);
    cfg_oe = 1;
    send(3'd4, 4'b0000, 1'b0, 14'h1234);
    chk(out_vld == 1 && out_data == 0 && out_ovf == 0, "R11 phase advanced", {out_ovf, out_data}, 0);
    // R8: codes 5..7 act as live data
    send(3'd5, 4'b0000, 1'b1, 14'h0ABC);
    chk(out_data == 14'h0ABC && out_ovf == 1, "R8 code5", out_data, 14'h0ABC);
    send(3'd7, 4'b0000, 1'b0, 14'h1357);
    chk(out_data == 14'h1357 && out_ovf == 0, "R8 code7", out_data, 14'h1357);
    // R12: DDR with overflow
    send(3'd1, 4'b0001, 1'b0, 14'h0000);
    chk(out_data == 0 && out_ovf == 1 && ddr_even == 7'h7F && ddr_odd == 7'h7F, "R12 ddr ones",
        {out_ovf, ddr_even, ddr_odd}, 15'h7FFF);
    // R11: disable clears outputs one clock later
    @(negedge clk); cfg_oe = 0;
    @(negedge clk);
    chk(ddr_even == 0 && ddr_odd == 0 && out_ovf == 0, "R11 clear", {ddr_even, ddr_odd}, 0);
    cfg_oe = 1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule